// File: doc/BRIEF.md
# Four-Port Tag-Steered Crossbar Switch

This block connects four input streams to four output streams. Each input word carries a destination tag in its top bits and a data payload below it. Each cycle, a scheduler reads the tag of the head word on every valid input. For every output, it picks one requesting input to connect. The resulting connection matrix is one-hot per output column. It drives a datapath built only from AND gates and OR trees, with no multiplexers. The tag is dropped on the way through, so each output carries the payload alone.

All edges use a ready/valid handshake. A word moves when its input is connected to an output and that output's sink is ready. When several inputs aim at the same output, they are served one per cycle in round-robin order. Outputs with different owners run in parallel in the same cycle.

Top module: `tagged_xbar_switch`

## Requirements
- R1: When output o is valid, `out_data[o]` equals the low 32 bits (payload) of the connected input's word; the tag bits never appear on an output.
- R2: Output o is driven only by an input that is valid and whose tag field (word bits [33:32]) equals o; a valid word with another tag never makes output o valid.
- R3: Each output is valid exactly when at least one valid input carries its tag, and then exactly one such input is connected.
- R4: `in_ready[i]` is high only when input i is valid, is connected to the output its tag names, and that output's `out_ready` is high.
- R5: After reset, contention for an output is won by the lowest-numbered requesting input. After a completed transfer from input w on output o, the search on o starts at input w+1, wrapping from 3 to 0.
- R6: The priority position of an output changes only on a cycle where that output both shows valid and sees ready; a stalled output keeps the same connection while its requests stay unchanged.
- R7: An output that is not valid drives all-zero data.
- R8: Inputs with distinct tags are all connected, and all of them complete, in the same cycle when their outputs are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 4x34 | Per input: {tag[1:0], payload[31:0]} |
| in_valid | input | 4 | Per-input word valid |
| in_ready | output | 4 | Per-input word accepted this cycle |
| out_data | output | 4x32 | Per-output payload |
| out_valid | output | 4 | Per-output word valid |
| out_ready | input | 4 | Per-output sink ready |

## Verification
The bench sweeps every combination of input valids, input tags and output readies, and compares each output against a round-robin model that it keeps itself. Several corner cases get directed tests. All four inputs contending for one output must rotate winners 0,1,2,3,0; a design that skips the pointer update, or advances it wrongly, repeats one winner. An output stalled under contention must keep its winner; a design that rotates on every cycle instead of on a completed transfer changes the payload mid-stall. Distinct tags must all go through in one cycle; a design with a single global arbiter would serialize them. A lone word tagged for one output must leave the others idle with zero data; a design with a broken tag decode or broken gating would leak data onto a foreign output.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
   function automatic int unsigned wrap_idx(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned n);
      int unsigned s;
      s = base + step;
      while (s >= n) s = s - n;
      return s;
   endfunction
endpackage

// File: rtl/xbar_req_decode.sv
module xbar_req_decode #(
   parameter int unsigned NUM_OUT = 4,
   parameter int unsigned TAG_W   = 2
) (
   input  logic               valid,
   input  logic [TAG_W-1:0]   tag,
   output logic [NUM_OUT-1:0] req_row
);
   always_comb begin
      req_row = '0;
      for (int o = 0; o < NUM_OUT; o++) begin
         req_row[o] = valid && (int'(tag) == o);
      end
   end
endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         advance,
   output logic [N-1:0] grant
);
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

   logic [IW-1:0] ptr_q;
   logic [IW-1:0] win_idx;
   logic          hit;

   always_comb begin
      grant   = '0;
      win_idx = '0;
      hit     = 1'b0;
      for (int k = 0; k < N; k++) begin
         if (!hit && req[xbar_pkg::wrap_idx(int'(ptr_q), k, N)]) begin
            hit     = 1'b1;
            win_idx = IW'(xbar_pkg::wrap_idx(int'(ptr_q), k, N));
            grant[xbar_pkg::wrap_idx(int'(ptr_q), k, N)] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (advance && hit) begin
         ptr_q <= IW'(xbar_pkg::wrap_idx(int'(win_idx), 1, N));
      end
   end

   // R3: one connection per output column
   p_onehot_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R6: no completed transfer and same requests -> same connection
   p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance) |=> ((req != $past(req)) || $stable(grant)));
endmodule

// File: rtl/xbar_gate_fabric.sv
module xbar_gate_fabric #(
   parameter int unsigned NUM_IN  = 4,
   parameter int unsigned NUM_OUT = 4,
   parameter int unsigned DATA_W  = 32
) (
   input  logic [NUM_OUT-1:0][NUM_IN-1:0] gnt,
   input  logic [NUM_IN-1:0][DATA_W-1:0]  in_data,
   input  logic [NUM_IN-1:0]              in_valid,
   input  logic [NUM_OUT-1:0]             out_ready,
   output logic [NUM_OUT-1:0][DATA_W-1:0] out_data,
   output logic [NUM_OUT-1:0]             out_valid,
   output logic [NUM_IN-1:0]              in_ready
);
   always_comb begin
      for (int o = 0; o < NUM_OUT; o++) begin
         out_data[o]  = '0;
         out_valid[o] = 1'b0;
         for (int i = 0; i < NUM_IN; i++) begin
            out_data[o]  = out_data[o] | (in_data[i] & {DATA_W{gnt[o][i]}});
            out_valid[o] = out_valid[o] | (gnt[o][i] & in_valid[i]);
         end
      end
   end

   always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
         in_ready[i] = 1'b0;
         for (int o = 0; o < NUM_OUT; o++) begin
            in_ready[i] = in_ready[i] | (gnt[o][i] & out_ready[o]);
         end
      end
   end
endmodule

// File: rtl/tagged_xbar_switch.sv
module tagged_xbar_switch #(
   parameter int unsigned NUM_IN  = 4,
   parameter int unsigned NUM_OUT = 4,
   parameter int unsigned DATA_W  = 32,
   localparam int unsigned TAG_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
   localparam int unsigned WORD_W = DATA_W + TAG_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_IN-1:0][WORD_W-1:0]  in_word,
   input  logic [NUM_IN-1:0]              in_valid,
   output logic [NUM_IN-1:0]              in_ready,
   output logic [NUM_OUT-1:0][DATA_W-1:0] out_data,
   output logic [NUM_OUT-1:0]             out_valid,
   input  logic [NUM_OUT-1:0]             out_ready
);
   if (NUM_IN < 2) begin : g_bad_in
      $error("NUM_IN must be at least 2");
   end
   if (NUM_OUT < 2 || (NUM_OUT & (NUM_OUT - 1)) != 0) begin : g_bad_out
      $error("NUM_OUT must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [NUM_IN-1:0][NUM_OUT-1:0] req_row;
   logic [NUM_OUT-1:0][NUM_IN-1:0] req_col;
   logic [NUM_OUT-1:0][NUM_IN-1:0] gnt;
   logic [NUM_IN-1:0][DATA_W-1:0]  payload;
   logic [NUM_IN-1:0][TAG_W-1:0]   tag;

   for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      assign payload[i] = in_word[i][DATA_W-1:0];
      assign tag[i]     = in_word[i][WORD_W-1:DATA_W];
      xbar_req_decode #(.NUM_OUT(NUM_OUT), .TAG_W(TAG_W)) u_dec (
         .valid   (in_valid[i]),
         .tag     (tag[i]),
         .req_row (req_row[i])
      );
      for (genvar o = 0; o < NUM_OUT; o++) begin : g_tr
         assign req_col[o][i] = req_row[i][o];
      end
      // R4: acceptance needs a valid word and a ready destination
      p_ready_needs_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
         in_ready[i] |-> (in_valid[i] && out_ready[tag[i]]));
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      xbar_rr_arb #(.N(NUM_IN)) u_arb (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (req_col[o]),
         .advance (out_valid[o] && out_ready[o]),
         .grant   (gnt[o])
      );
      // R7: idle output carries zeros
      p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!out_valid[o]) |-> (out_data[o] == '0));
   end

   xbar_gate_fabric #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_fab (
      .gnt       (gnt),
      .in_data   (payload),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_valid (out_valid),
      .in_ready  (in_ready)
   );

   // R3: at most as many completions as outputs
   p_accept_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(in_ready) <= $countones(out_valid & out_ready));
endmodule

// File: tb/tb_tagged_xbar_switch.sv
module tb_tagged_xbar_switch;
   localparam int NI = 4;
   localparam int NO = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0][33:0] in_word = '0;
   logic [3:0]       in_valid = '0;
   logic [3:0]       in_ready;
   logic [3:0][31:0] out_data;
   logic [3:0]       out_valid;
   logic [3:0]       out_ready = '0;

   int total = 0;
   int bad = 0;
   int ptr_m [NO];
   bit finished = 1'b0;

   always #5 clk = ~clk;

   tagged_xbar_switch dut (
      .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
      .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
      .out_ready(out_ready)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pay(input int i, input int c);
      return (32'h1000_0000 * (i + 1)) ^ (c * 32'h0001_0203) ^ 32'h0000_5A5A;
   endfunction

   // drive one cycle, compare against the round-robin model, advance model
   task automatic step(input logic [3:0] v, input logic [7:0] tags,
                       input logic [3:0] rdy, input int c);
      int win [NO];
      @(negedge clk);
      for (int i = 0; i < NI; i++) in_word[i] = {tags[2*i +: 2], pay(i, c)};
      in_valid  = v;
      out_ready = rdy;
      #1;
      for (int o = 0; o < NO; o++) begin
         win[o] = -1;
         for (int k = 0; k < NI; k++) begin
            int idx;
            idx = (ptr_m[o] + k) % NI;
            if (win[o] < 0 && v[idx] && int'(tags[2*idx +: 2]) == o) win[o] = idx;
         end
         chk(out_valid[o] == (win[o] >= 0), "R3", out_valid[o], win[o] >= 0);
         if (win[o] >= 0)
            chk(out_data[o] == pay(win[o], c), "R1", out_data[o], pay(win[o], c));
         else
            chk(out_data[o] == 32'h0, "R7", out_data[o], 0);
      end
      for (int i = 0; i < NI; i++) begin
         bit er;
         int t;
         t  = int'(tags[2*i +: 2]);
         er = v[i] && (win[t] == i) && rdy[t];
         chk(in_ready[i] == er, "R4", in_ready[i], er);
      end
      for (int o = 0; o < NO; o++)
         if (win[o] >= 0 && rdy[o]) ptr_m[o] = (win[o] + 1) % NI;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int o = 0; o < NO; o++) ptr_m[o] = 0;
      repeat (3) @(posedge clk);
      #1;
      chk(out_valid == 4'h0, "R3 reset", out_valid, 0);
      chk(in_ready == 4'h0, "R4 reset", in_ready, 0);
      chk(out_data == '0, "R7 reset", 0, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5: all four target output 2; winners rotate 0,1,2,3,0
      for (int n = 0; n < 5; n++) begin
         step(4'hF, 8'b10_10_10_10, 4'hF, n);
         chk(in_ready == (4'b1 << (n % 4)), "R5 rotation", in_ready, 4'b1 << (n % 4));
      end
      // R6: output 2 stalled; winner stays input 1
      for (int n = 0; n < 3; n++) begin
         step(4'hF, 8'b10_10_10_10, 4'h0, 10 + n);
         chk(out_data[2] == pay(1, 10 + n), "R6 stall hold", out_data[2], pay(1, 10 + n));
      end
      step(4'hF, 8'b10_10_10_10, 4'h4, 20);
      chk(in_ready == 4'b0010, "R6 release", in_ready, 4'b0010);
      // R8: distinct tags all pass together
      step(4'hF, 8'b00_01_10_11, 4'hF, 30);
      chk(in_ready == 4'hF, "R8 parallel", in_ready, 4'hF);
      // R2: lone word tagged 3 leaves outputs 0..2 idle
      step(4'b0001, 8'b00_00_00_11, 4'hF, 40);
      chk(out_valid == 4'b1000, "R2 tag steer", out_valid, 4'b1000);
      // R2: invalid words never drive outputs
      step(4'h0, 8'b00_01_10_11, 4'hF, 41);
      chk(out_valid == 4'h0, "R2 invalid", out_valid, 0);

      // sweep: valids x tags x readies
      for (int v = 0; v < 16; v++)
         for (int t = 0; t < 256; t++)
            for (int r = 0; r < 16; r++)
               step(4'(v), 8'(t), 4'(r), 100 + v * 4096 + t * 16 + r);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule